// File: doc/BRIEF.md
# Offset-Started Periodic Event Generator

This block produces a periodic single-cycle event strobe locked to a frame timer. It watches the timer's position fields (slot, chip-table index, chip and sub-chip) together with the timer's reference tick. Once enabled, it waits for the tick on which the timer position equals a programmed start offset. From that tick on it counts reference ticks and fires an event every `dly_cnt_i + 1` ticks. The period register holds the desired delay minus one, so a value of 31 gives one event every 32 ticks.

Two instances with different chip offsets, for example 0 and 12, give two strobes with the same period and a fixed stagger. Dropping the enable returns the block to its idle state. A fresh offset match is then needed before counting starts again. There is no data stream, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `cde_delay_evgen`

## Requirements
- R1: After reset, `event_o` is 0 and the block is idle, waiting for an offset match.
- R2: While enabled but before an offset match, no number of ticks produces an event.
- R3: The block arms only on a cycle with `tick_i`=1 and `en_i`=1 in which all four timer fields equal their offsets. A mismatch in any single field leaves it idle.
- R4: The tick that arms the block is tick 0. The first event follows the tick numbered `dly_cnt_i`+1 after it, with `event_o`=1 in the clock cycle after that tick's edge.
- R5: After an event the count reloads and counting continues, so events repeat every `dly_cnt_i`+1 ticks without a new offset match.
- R6: Cycles with `tick_i`=0 neither advance the count nor produce an event.
- R7: Each firing tick gives `event_o`=1 for exactly one cycle.
- R8: With `en_i`=0 the count and the armed state are cleared and `event_o` is 0 one cycle later. After re-enabling, counting waits for a new offset match.
- R9: With `dly_cnt_i`=0, every tick after the arming tick produces an event.
- R10: If `dly_cnt_i` is lowered to or below the current count, the next tick fires an event and restarts the count from zero.
- R11: An offset match that arrives while the block is armed does not restart the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Generator enable |
| tick_i | input | 1 | Reference (sub-chip) tick |
| t_slot_i | input | SLOT_W | Timer slot field |
| t_idx_i | input | IDX_W | Timer chip-table index field |
| t_chip_i | input | CHIP_W | Timer chip field |
| t_sub_i | input | SUB_W | Timer sub-chip field |
| off_slot_i | input | SLOT_W | Start offset, slot |
| off_idx_i | input | IDX_W | Start offset, chip-table index |
| off_chip_i | input | CHIP_W | Start offset, chip |
| off_sub_i | input | SUB_W | Start offset, sub-chip |
| dly_cnt_i | input | CNT_W | Period minus one, in ticks |
| event_o | output | 1 | Single-cycle event strobe |

## Verification
A wrong armed flag shows up at the ports in one of two ways. Events may appear before the offset match, or they may never appear at all. Either is visible within `dly_cnt_i`+2 ticks of the moment the flag goes wrong. A corrupted count shifts the phase, so the next event lands on the wrong tick, no later than one full period after the fault. A missed reload turns the period into a count-overflow interval, which is detected at the next expected event.

// File: rtl/cde_pkg.sv
package cde_pkg;
  parameter int SLOT_W = 4;
  parameter int IDX_W  = 3;
  parameter int CHIP_W = 12;
  parameter int SUB_W  = 3;

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [IDX_W-1:0]  idx;
    logic [CHIP_W-1:0] chip;
    logic [SUB_W-1:0]  sub;
  } tpos_t;
endpackage

// File: rtl/cde_pos_match.sv
module cde_pos_match
  import cde_pkg::*;
(
  input  tpos_t cur_i,
  input  tpos_t ref_i,
  output logic  hit_o
);
  logic [3:0] field_eq;

  always_comb begin
    field_eq[0] = (cur_i.slot == ref_i.slot);
    field_eq[1] = (cur_i.idx  == ref_i.idx);
    field_eq[2] = (cur_i.chip == ref_i.chip);
    field_eq[3] = (cur_i.sub  == ref_i.sub);
    hit_o = &field_eq;
  end
endmodule

// File: rtl/cde_arm.sv
module cde_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic hit_i,
  output logic armed_o,
  output logic start_o
);
  // Arming happens on the matching tick only while idle.
  assign start_o = en_i & ~armed_o & tick_i & hit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_o <= 1'b0;
    else if (!en_i)   armed_o <= 1'b0;
    else if (start_o) armed_o <= 1'b1;
  end
endmodule

// File: rtl/cde_period_cnt.sv
module cde_period_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             armed_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             event_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic wrap;

  // At or past the programmed count counts as full, so a lowered period
  // takes effect on the next tick.
  assign wrap = (cnt_o >= dly_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o   <= '0;
      event_o <= 1'b0;
    end else if (!en_i || start_i) begin
      cnt_o   <= '0;
      event_o <= 1'b0;
    end else if (armed_i && tick_i) begin
      event_o <= wrap;
      cnt_o   <= wrap ? '0 : cnt_o + ONE;
    end else begin
      event_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cde_delay_evgen.sv
module cde_delay_evgen
  import cde_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [SLOT_W-1:0] t_slot_i,
  input  logic [IDX_W-1:0]  t_idx_i,
  input  logic [CHIP_W-1:0] t_chip_i,
  input  logic [SUB_W-1:0]  t_sub_i,
  input  logic [SLOT_W-1:0] off_slot_i,
  input  logic [IDX_W-1:0]  off_idx_i,
  input  logic [CHIP_W-1:0] off_chip_i,
  input  logic [SUB_W-1:0]  off_sub_i,
  input  logic [CNT_W-1:0]  dly_cnt_i,
  output logic              event_o
);
  tpos_t            cur_pos, off_pos;
  logic             pos_hit, armed, start;
  logic [CNT_W-1:0] cnt;

  assign cur_pos = '{slot: t_slot_i, idx: t_idx_i, chip: t_chip_i, sub: t_sub_i};
  assign off_pos = '{slot: off_slot_i, idx: off_idx_i, chip: off_chip_i, sub: off_sub_i};

  cde_pos_match u_match (
    .cur_i (cur_pos),
    .ref_i (off_pos),
    .hit_o (pos_hit)
  );

  cde_arm u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .tick_i  (tick_i),
    .hit_i   (pos_hit),
    .armed_o (armed),
    .start_o (start)
  );

  cde_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .armed_i (armed),
    .start_i (start),
    .tick_i  (tick_i),
    .dly_i   (dly_cnt_i),
    .cnt_o   (cnt),
    .event_o (event_o)
  );
endmodule

// File: rtl/cde_checker.sv
module cde_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             tick_i,
  input logic             hit_i,
  input logic             armed_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             event_i
);
  assert_idle_cnt_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_i |-> (cnt_i == '0));

  assert_no_event_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |-> $past(armed_i));

  assert_arm_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_i) |-> $past(hit_i && tick_i && en_i));

  assert_reload_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |-> (cnt_i == '0));

  assert_event_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |-> $past(tick_i));

  assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> (!event_i && !armed_i));
endmodule

bind cde_delay_evgen cde_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_i    (en_i),
  .tick_i  (tick_i),
  .hit_i   (pos_hit),
  .armed_i (armed),
  .cnt_i   (cnt),
  .event_i (event_o)
);

// File: tb/cde_delay_evgen_bench.sv
module cde_delay_evgen_bench;
  import cde_pkg::*;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, tick = 1'b0;
  logic [SLOT_W-1:0] t_slot, off_slot;
  logic [IDX_W-1:0]  t_idx,  off_idx;
  logic [CHIP_W-1:0] t_chip, off_chip;
  logic [SUB_W-1:0]  t_sub,  off_sub;
  logic [CNT_W-1:0]  dly = '0;
  logic              event_o;

  int checks = 0, failures = 0;
  // Bench model state, from the requirements.
  bit m_armed = 0;
  int m_cnt = 0;
  bit m_ev = 0;

  always #4 clk = ~clk;

  cde_delay_evgen #(.CNT_W(CNT_W)) u_cde_delay_evgen (
    .clk(clk), .rst_n(rst_n), .en_i(en), .tick_i(tick),
    .t_slot_i(t_slot), .t_idx_i(t_idx), .t_chip_i(t_chip), .t_sub_i(t_sub),
    .off_slot_i(off_slot), .off_idx_i(off_idx), .off_chip_i(off_chip), .off_sub_i(off_sub),
    .dly_cnt_i(dly), .event_o(event_o)
  );

  task automatic check(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s event_o actual=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  // mode 0: one random field off, 1: full match, 2..5: field (mode-2) off
  task automatic set_pos(input int mode);
    int f;
    t_slot = off_slot; t_idx = off_idx; t_chip = off_chip; t_sub = off_sub;
    f = (mode == 0) ? int'($urandom % 4) : mode - 2;
    if (mode != 1) begin
      case (f)
        0: t_slot = off_slot + 1'b1;
        1: t_idx  = off_idx + 1'b1;
        2: t_chip = off_chip + 1'b1;
        default: t_sub = off_sub + 1'b1;
      endcase
    end
  endtask

  function automatic int expected_next(input bit e, input bit tk, input bit hit, input int d);
    // Returns the event expected one cycle later; updates the model state.
    bit ev;
    ev = 0;
    if (!e) begin m_armed = 0; m_cnt = 0; end
    else if (!m_armed) begin
      if (tk && hit) begin m_armed = 1; m_cnt = 0; end
    end else if (tk) begin
      ev = (m_cnt >= d);
      m_cnt = ev ? 0 : m_cnt + 1;
    end
    return int'(ev);
  endfunction

  // Called at a falling edge: drive, predict, wait one cycle, compare.
  task automatic step(input bit tk, input int mode, input string req);
    tick = tk;
    set_pos(mode);
    m_ev = expected_next(en, tk, mode == 1, int'(dly));
    @(negedge clk);
    check(event_o, m_ev, req);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int evn;
    void'($urandom(32'd1234));
    off_slot = 4'd5; off_idx = 3'd2; off_chip = 12'd100; off_sub = 3'd3;
    set_pos(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(event_o, 1'b0, "R1 reset");

    en = 1'b1; dly = 16'd3;
    for (int i = 0; i < 12; i++) step(1'b1, 0, "R2 no match");
    for (int m = 2; m < 6; m++) step(1'b1, m, "R3 partial match");
    step(1'b0, 1, "R3 match without tick");
    for (int i = 0; i < 8; i++) step(1'b1, 0, "R3 still idle");

    // Arm, then events on ticks 4, 8 (dly=3).
    step(1'b1, 1, "R4 arm");
    for (int i = 1; i <= 3; i++) step(1'b1, 0, "R4 before first");
    step(1'b1, 0, "R4 first event");
    if (event_o !== 1'b1) $display("FAIL R4 first event actual=%0b expected=1", event_o);
    for (int i = 0; i < 8; i++) step(1'b1, 0, "R5 repeat");
    for (int i = 0; i < 10; i++) step(i[0], 0, "R6 tick gaps");
    step(1'b1, 1, "R11 match while armed");
    for (int i = 0; i < 6; i++) step(1'b1, 0, "R11 phase kept");

    dly = 16'd0;
    step(1'b1, 0, "R9 zero period");
    step(1'b0, 0, "R7 single cycle");
    step(1'b1, 0, "R9 zero period");
    step(1'b1, 0, "R9 zero period");

    dly = 16'd10;
    for (int i = 0; i < 7; i++) step(1'b1, 0, "R10 run up");
    dly = 16'd2;
    step(1'b1, 0, "R10 lowered count fires");
    step(1'b1, 0, "R10 restart");

    en = 1'b0;
    step(1'b1, 1, "R8 disabled");
    en = 1'b1;
    for (int i = 0; i < 10; i++) step(1'b1, 0, "R8 waits for match");

    // Random phase.
    evn = 0;
    for (int i = 0; i < 5000; i++) begin
      if ($urandom % 200 == 0) en = ~en;
      if ($urandom % 300 == 0) dly = CNT_W'($urandom % 12);
      step(($urandom % 2) == 1, ($urandom % 10 == 0) ? 1 : 0, "R5 random");
      if (event_o) evn++;
    end
    checks++;
    if (evn == 0) begin
      failures++;
      $display("FAIL R5 random events actual=%0d expected>0", evn);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule